// File: doc/BRIEF.md
# Modem Handshake Control, Status and Loopback Unit

This unit sits beside the serial engines of an asynchronous serial port and owns the modem handshake lines. A control register written by the host drives four active-low handshake outputs: terminal ready, request to send, and two general-purpose outputs. Four active-low handshake inputs come from the attached equipment: clear to send, set ready, ring and carrier detect. They are brought into the clock domain and reported through a status register. That register carries each input's current active-high level and a sticky change flag for it. Any raised change flag raises the modem interrupt request, which the host clears by reading the status register.

A loop bit in the control register turns on a local self-test path. In that mode the serial output pin is held idle high. The transmit shifter's bit is routed to the receiver in place of the serial input pin. The external handshake inputs are ignored, and the four handshake output pins go inactive high. The status inputs are fed instead from the control bits: terminal ready appears as clear to send, request to send as set ready, general output 1 as ring, and general output 2 as carrier detect. Software can therefore exercise the whole status and interrupt path without external wiring.

Every register access completes in the cycle its strobe is high. No interface here carries a stream, so no port has back-pressure. Control readback is always valid, and status read data is valid in the cycle `sts_re` is high.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, control readback and status read data are 00h, all four handshake output pins are high and `modem_irq` is low.
- R2: Control bits 0..3 (terminal ready, request to send, out1, out2) drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` inverted from the clock edge that writes them, when loop is off. Control readback bits 4..0 return what was written and bits 7..5 read 0.
- R3: Outside loop, status bits 4..7 show the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` in that order. They are valid from the third clock edge after an input changes: two synchronizer flops and one status flop.
- R4: Status bits 0, 1 and 3 are set by any change, either direction, of the clear-to-send, set-ready and carrier-detect levels.
- R5: Status bit 2 is set only when the ring level goes from active to inactive, that is, when `ri_n` returns from low to high.
- R6: Status bits 0..3 stay set until a status read. The read returns them and clears them at that edge, but a change detected at that same edge leaves its bit set.
- R7: `modem_irq` is high exactly when any of status bits 0..3 is set.
- R8: With loop (control bit 4) set, `ser_o` is 1 and `rx_ser_o` follows `tx_ser_i`. With loop clear, `ser_o` follows `tx_ser_i` and `rx_ser_o` follows `rx_pin_i`.
- R9: With loop set, all four handshake output pins are high, and changes on the four handshake inputs affect neither status bits nor `modem_irq`.
- R10: With loop set, status bits 4, 5, 6 and 7 take the values of control bits 0, 1, 2 and 3 one edge after they are written, and their changes set the change flags per R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_re | input | 1 | Status register read strobe (clears change flags) |
| sts_rdata | output | 8 | Status register read data |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Set ready, active low |
| ri_n | input | 1 | Ring, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| tx_ser_i | input | 1 | Serial bit from transmit shifter |
| ser_o | output | 1 | Serial output pin |
| rx_pin_i | input | 1 | Serial input pin |
| rx_ser_o | output | 1 | Serial bit to the receiver |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
A stale or wrong level register shows at the ports as change flags on the next status read: wrong bits, or bits that never clear. A sweep from every input pattern to every other pattern exposes any wrong flag within three edges of the change. A wrong flag register also shows at once on `modem_irq`, which must match the flags on every read. A wrong loop select shows in the cycle after the control write, on the output pins, on the serial routing, or as status levels that disagree with the written control nibble. Flags raised by inputs that loop should have ignored show on the next read.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int unsigned MDM_N    = 4;
  localparam int unsigned CTL_W    = 5;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned IDX_CTS  = 0;
  localparam int unsigned IDX_DSR  = 1;
  localparam int unsigned IDX_RI   = 2;
  localparam int unsigned IDX_DCD  = 3;
  localparam int unsigned LOOP_BIT = 4;
  typedef logic [MDM_N-1:0] mdm_vec_t;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl,
  output logic [REG_W-1:0] rdata,
  output logic             loop_en,
  output mdm_vec_t         pins_n
);
  logic unused_hi;
  assign unused_hi = ^wdata[REG_W-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl <= '0;
    else if (we) ctl <= wdata[CTL_W-1:0];
  end

  assign loop_en = ctl[LOOP_BIT];
  assign rdata   = {{(REG_W-CTL_W){1'b0}}, ctl};

  for (genvar i = 0; i < MDM_N; i++) begin : g_pin
    assign pins_n[i] = loop_en | ~ctl[i];
  end

  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[CTL_W-1:0] == $past(wdata[CTL_W-1:0])));
endmodule

// File: rtl/mcs_status.sv
module mcs_status
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  mdm_vec_t         lvl_in,
  output logic [REG_W-1:0] sts,
  output logic             irq
);
  localparam mdm_vec_t NONRI = ~(mdm_vec_t'(1) << IDX_RI);

  mdm_vec_t lvl_q, dlt_q, ev;

  always_comb begin
    ev         = (lvl_in ^ lvl_q) & NONRI;
    ev[IDX_RI] = lvl_q[IDX_RI] & ~lvl_in[IDX_RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dlt_q <= '0;
    end else begin
      lvl_q <= lvl_in;
      dlt_q <= (rd_clr ? '0 : dlt_q) | ev;
    end
  end

  assign sts = {lvl_q, dlt_q};
  assign irq = |dlt_q;

  // R6
  sticky_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (lvl_in == lvl_q)) |=> (dlt_q == '0));
  // R5
  ring_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt_q[IDX_RI]) |-> ($past(lvl_q[IDX_RI]) && !lvl_q[IDX_RI]));
  // R4
  level_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((lvl_q ^ $past(lvl_q)) & NONRI) != '0) |->
      ((dlt_q & (lvl_q ^ $past(lvl_q)) & NONRI) == ((lvl_q ^ $past(lvl_q)) & NONRI)));
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mcs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_re,
  output logic [7:0] sts_rdata,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  input  logic       tx_ser_i,
  output logic       ser_o,
  input  logic       rx_pin_i,
  output logic       rx_ser_o,
  output logic       modem_irq
);
  logic [CTL_W-1:0] ctl;
  logic             loop_en;
  mdm_vec_t         pins_n, ext_n, ext_sync_n, lvl;

  mcs_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .ctl(ctl), .rdata(ctl_rdata), .loop_en(loop_en), .pins_n(pins_n)
  );

  assign dtr_n  = pins_n[IDX_CTS];
  assign rts_n  = pins_n[IDX_DSR];
  assign out1_n = pins_n[IDX_RI];
  assign out2_n = pins_n[IDX_DCD];

  always_comb begin
    ext_n          = '1;
    ext_n[IDX_CTS] = cts_n;
    ext_n[IDX_DSR] = dsr_n;
    ext_n[IDX_RI]  = ri_n;
    ext_n[IDX_DCD] = dcd_n;
  end

  mcs_sync #(.W(MDM_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_n), .q(ext_sync_n)
  );

  assign lvl = loop_en ? ctl[MDM_N-1:0] : ~ext_sync_n;

  mcs_status u_sts (
    .clk(clk), .rst_n(rst_n), .rd_clr(sts_re), .lvl_in(lvl),
    .sts(sts_rdata), .irq(modem_irq)
  );

  assign ser_o    = loop_en ? 1'b1 : tx_ser_i;
  assign rx_ser_o = loop_en ? tx_ser_i : rx_pin_i;

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modem_irq) |-> (sts_rdata[3:0] != 4'h0));
  // R8
  loop_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[LOOP_BIT] |-> (ser_o && (rx_ser_o == tx_ser_i)));
  // R9
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[LOOP_BIT]) |=> ({out2_n, out1_n, rts_n, dtr_n} == 4'hF));
  // R10
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[LOOP_BIT] && $past(ctl_rdata[LOOP_BIT])) |->
      (sts_rdata[7:4] == $past(ctl_rdata[3:0])));
endmodule

// File: tb/modem_ctl_stat_tb.sv
`timescale 1ns/1ps
module modem_ctl_stat_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, sts_re = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata, sts_rdata;
  logic [3:0] pin_n = 4'hF;
  logic dtr_n, rts_n, out1_n, out2_n;
  logic tx_ser_i = 1'b1, rx_pin_i = 1'b1;
  logic ser_o, rx_ser_o, modem_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_ctl_stat u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
    .cts_n(pin_n[0]), .dsr_n(pin_n[1]), .ri_n(pin_n[2]), .dcd_n(pin_n[3]),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .tx_ser_i(tx_ser_i), .ser_o(ser_o), .rx_pin_i(rx_pin_i),
    .rx_ser_o(rx_ser_o), .modem_irq(modem_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    sts_re = 1'b1;
    #0.5 v = sts_rdata;
    @(posedge clk);
    @(negedge clk);
    sts_re = 1'b0;
  endtask

  function automatic logic [3:0] exp_dlt(input logic [3:0] o, input logic [3:0] n);
    return ((o ^ n) & 4'b1011) | (o & ~n & 4'b0100);
  endfunction

  function automatic logic [3:0] pins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 ctl", ctl_rdata, 8'h00);
    check("R1 sts", sts_rdata, 8'h00);
    check("R1 pins", pins(), 4'hF);
    check("R1 irq", modem_irq, 0);

    // R2 control drive and readback
    for (int v = 0; v < 16; v++) begin
      wr(8'hE0 | 8'(v));
      check("R2 readback", ctl_rdata, v);
      check("R2 pins", pins(), ~v & 4'hF);
    end
    wr(8'h00);

    // R8 serial routing, loop off
    for (int k = 0; k < 4; k++) begin
      tx_ser_i = k[0]; rx_pin_i = k[1]; #0.5;
      check("R8 ser_o", ser_o, k[0]);
      check("R8 rx_ser_o", rx_ser_o, k[1]);
      @(negedge clk);
    end

    // R3 R4 R5 R6 R7 exhaustive transitions of external inputs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pin_n = ~4'(a);
        tick(4);
        rd(s);
        pin_n = ~4'(b);
        tick(4);
        check("R7 irq", modem_irq, exp_dlt(4'(a), 4'(b)) != 0);
        rd(s);
        check("R3 levels", s[7:4], b);
        check("R4 R5 flags", s[3:0], exp_dlt(4'(a), 4'(b)));
        rd(s);
        check("R6 cleared", s, {4'(b), 4'h0});
      end
    end
    pin_n = 4'hF;
    tick(4);
    rd(s);

    // R9 R10 loop mode: all control nibble transitions, inputs toggled meanwhile
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(8'h10 | 8'(a));
        tick(1);
        rd(s);
        pin_n = 4'(a ^ b ^ 5);
        wr(8'h10 | 8'(b));
        check("R9 pins", pins(), 4'hF);
        tick(4);
        rd(s);
        check("R10 levels", s[7:4], b);
        check("R9 R10 flags", s[3:0], exp_dlt(4'(a), 4'(b)));
      end
    end

    // R8 loop routing
    for (int k = 0; k < 4; k++) begin
      tx_ser_i = k[0]; rx_pin_i = k[1]; #0.5;
      check("R8 loop ser_o", ser_o, 1);
      check("R8 loop rx_ser_o", rx_ser_o, k[0]);
      @(negedge clk);
    end

    // R6 change arriving at the clearing edge is kept
    wr(8'h10);
    tick(1);
    rd(s);
    ctl_we = 1'b1; ctl_wdata = 8'h11;
    tick(1);
    ctl_we = 1'b0;
    rd(s);
    check("R6 read value", s[3:0], 0);
    #0.5;
    check("R6 kept flag", sts_rdata[3:0], 4'h1);
    check("R7 irq kept", modem_irq, 1);
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule